// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This unit owns the fetch address of a small controller with a 1K-word instruction space. Every cycle it picks the next fetch address from one of several sources: the next sequential word, an absolute target from the decoder for a jump or a call, the top of a small return-address stack for a return, a fixed interrupt entry address, or a computed jump. In a computed jump the accumulator is added to or subtracted from the low byte of the counter. A carry out of an addition moves the upper bits up by one. A borrow from a subtraction does not change them.

Calls and interrupt entries both push onto the same four-entry circular return stack. The stack pointer is an output so the decoder can read it. A single global interrupt enable bit is cleared on interrupt entry and set by a return from interrupt. A one-level shadow buffer holds a saved copy of the accumulator and the flag byte for an interrupt handler to restore. The two reset-cause bits of the flag byte are never taken from the saved copy; they always follow the live flag input. Decoding, the ALU and interrupt arbitration live elsewhere and reach this unit only through strobes.

Top module: `fetch_pc_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the fetch address is 0x000, the stack pointer is 0, the interrupt enable is 0, and both shadow registers read as 0 (apart from the live cause bits of the flag byte).
- R2: When no strobe is active, the fetch address increases by one each clock, and 0x3FF is followed by 0x000.
- R3: A jump strobe loads the target address. A call strobe loads the target address, pushes the address of the call plus one (mod 1024), and raises the stack pointer by one.
- R4: A return strobe loads the fetch address from the most recently pushed entry and lowers the stack pointer by one.
- R5: An interrupt-take strobe pushes the current fetch address, loads 0x008, raises the stack pointer and clears the interrupt enable, all on the same clock edge.
- R6: A return-from-interrupt strobe pops the stack exactly as a return does and also sets the interrupt enable.
- R7: An add strobe makes the new low byte (bits 7..0) equal to low byte + accumulator mod 256. When that sum exceeds 255, bits 9..8 increase by one, and 3 wraps to 0.
- R8: A subtract strobe makes the new low byte equal to low byte − accumulator mod 256, and bits 9..8 keep their value even when the subtraction borrows.
- R9: The stack pointer is two bits wide and wraps. A fifth push with four entries held overwrites the oldest entry and leaves the pointer at 1. Later pops return entries newest first and wrap below 0.
- R10: When several strobes are active together, exactly one acts, in this order: interrupt-take, return-from-interrupt, return, call, jump, add, subtract.
- R11: A shadow-save strobe captures the accumulator and flag bits 5..0 on the next edge. The restored flag output takes bits 5..0 from the saved copy and bits 7..6 (the reset-cause bits) from the live flag input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| jmpEn | input | 1 | Absolute jump strobe |
| callEn | input | 1 | Call strobe |
| retEn | input | 1 | Return strobe |
| retiEn | input | 1 | Return-from-interrupt strobe |
| irqTake | input | 1 | Interrupt entry strobe |
| addPclEn | input | 1 | Computed jump, low byte plus accumulator |
| subPclEn | input | 1 | Computed jump, low byte minus accumulator |
| targetAddr | input | 10 | Jump or call target |
| accIn | input | 8 | Accumulator value |
| flagIn | input | 8 | Live flag byte; bits 7..6 are reset-cause bits |
| shadowSave | input | 1 | Capture accumulator and flags into the shadow buffer |
| fetchAddr | output | 10 | Current fetch address |
| stackPtr | output | 2 | Return-stack pointer |
| gieOut | output | 1 | Global interrupt enable |
| accSaved | output | 8 | Saved accumulator |
| flagRestored | output | 8 | Flag byte for restore, cause bits taken from the live input |

## Verification
The bench uses the default parameters: a 10-bit counter with an 8-bit low byte, a four-entry stack and an interrupt entry address of 0x008. With a 10-bit counter, a jump to 0x3FE puts the increment wrap two cycles away. Computed jumps from 0x3F0 and 0x0F0 exercise the carry into the high part and its 3-to-0 wrap. With only four stack slots, five nested calls followed by five returns reach both the overwrite of the oldest entry and the pointer wrapping below zero.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [2:0] {
    NX_INC  = 3'd0,
    NX_LOAD = 3'd1,
    NX_POP  = 3'd2,
    NX_VEC  = 3'd3,
    NX_ADD  = 3'd4,
    NX_SUB  = 3'd5
  } nextSel_e;

  typedef struct packed {
    nextSel_e sel;
    logic     push;
    logic     pushCur;  // push the current address instead of address+1
    logic     pop;
    logic     gieSet;
    logic     gieClr;
  } pcCtl_t;

endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic   irqTake,
  input  logic   retiEn,
  input  logic   retEn,
  input  logic   callEn,
  input  logic   jmpEn,
  input  logic   addPclEn,
  input  logic   subPclEn,
  output pcCtl_t ctl
);

  always_comb begin
    ctl = '{sel: NX_INC, push: 1'b0, pushCur: 1'b0, pop: 1'b0,
            gieSet: 1'b0, gieClr: 1'b0};
    if (irqTake) begin
      ctl.sel     = NX_VEC;
      ctl.push    = 1'b1;
      ctl.pushCur = 1'b1;
      ctl.gieClr  = 1'b1;
    end else if (retiEn) begin
      ctl.sel    = NX_POP;
      ctl.pop    = 1'b1;
      ctl.gieSet = 1'b1;
    end else if (retEn) begin
      ctl.sel = NX_POP;
      ctl.pop = 1'b1;
    end else if (callEn) begin
      ctl.sel  = NX_LOAD;
      ctl.push = 1'b1;
    end else if (jmpEn) begin
      ctl.sel = NX_LOAD;
    end else if (addPclEn) begin
      ctl.sel = NX_ADD;
    end else if (subPclEn) begin
      ctl.sel = NX_SUB;
    end
  end

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int ADDR_W = 10,
  parameter int LOW_W  = 8,
  parameter int DEPTH  = 4,
  localparam int SP_W  = $clog2(DEPTH),
  localparam int HI_W  = ADDR_W - LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic [ADDR_W-1:0] topAddr,
  output logic [SP_W-1:0]   sp
);

  logic [ADDR_W-1:0] entryVal [DEPTH];
  logic [SP_W-1:0]   spDec;

  assign spDec = sp - SP_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic [LOW_W-1:0] loQ;
    logic [HI_W-1:0]  hiQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loQ <= '0;
        hiQ <= '0;
      end else if (push && sp == SP_W'(g)) begin
        loQ <= pushAddr[LOW_W-1:0];
        hiQ <= pushAddr[ADDR_W-1:LOW_W];
      end
    end
    assign entryVal[g] = {hiQ, loQ};
  end

  assign topAddr = entryVal[spDec];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sp <= '0;
    else if (push) sp <= sp + SP_W'(1);
    else if (pop)  sp <= spDec;
  end

endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LOW_W  = 8,
  parameter int VEC    = 8,
  localparam int HI_W  = ADDR_W - LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcCtl_t            ctl,
  input  logic [ADDR_W-1:0] target,
  input  logic [LOW_W-1:0]  acc,
  input  logic [ADDR_W-1:0] popAddr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pushAddr,
  output logic              gie
);

  logic [LOW_W-1:0]  pcLow;
  logic [HI_W-1:0]   pcHigh;
  logic [LOW_W:0]    sumLow;
  logic [LOW_W-1:0]  diffLow;
  logic [HI_W-1:0]   hiBumped;
  logic [ADDR_W-1:0] pcPlusOne;
  logic [ADDR_W-1:0] pcNext;

  assign pcLow     = pc[LOW_W-1:0];
  assign pcHigh    = pc[ADDR_W-1:LOW_W];
  assign sumLow    = {1'b0, pcLow} + {1'b0, acc};
  assign diffLow   = pcLow - acc;
  assign hiBumped  = pcHigh + HI_W'(sumLow[LOW_W]);
  assign pcPlusOne = pc + ADDR_W'(1);
  assign pushAddr  = ctl.pushCur ? pc : pcPlusOne;

  always_comb begin
    unique case (ctl.sel)
      NX_LOAD: pcNext = target;
      NX_POP:  pcNext = popAddr;
      NX_VEC:  pcNext = ADDR_W'(VEC);
      NX_ADD:  pcNext = {hiBumped, sumLow[LOW_W-1:0]};
      NX_SUB:  pcNext = {pcHigh, diffLow};
      default: pcNext = pcPlusOne;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else       pc <= pcNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gie <= 1'b0;
    else if (ctl.gieClr) gie <= 1'b0;
    else if (ctl.gieSet) gie <= 1'b1;
  end

endmodule

// File: rtl/shadow_buf.sv
module shadow_buf #(
  parameter int            DATA_W     = 8,
  parameter logic [7:0]    CAUSE_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              saveEn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] flagIn,
  output logic [DATA_W-1:0] accSaved,
  output logic [DATA_W-1:0] flagRestored
);

  localparam logic [DATA_W-1:0] MASK = DATA_W'(CAUSE_MASK);

  logic [DATA_W-1:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSaved <= '0;
      flagQ    <= '0;
    end else if (saveEn) begin
      accSaved <= accIn;
      flagQ    <= flagIn & ~MASK;
    end
  end

  assign flagRestored = (flagIn & MASK) | flagQ;

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import pc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LOW_W  = 8,
  parameter int DEPTH  = 4,
  parameter int VEC    = 8,
  localparam int SP_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              jmpEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              retiEn,
  input  logic              irqTake,
  input  logic              addPclEn,
  input  logic              subPclEn,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [LOW_W-1:0]  accIn,
  input  logic [LOW_W-1:0]  flagIn,
  input  logic              shadowSave,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [SP_W-1:0]   stackPtr,
  output logic              gieOut,
  output logic [LOW_W-1:0]  accSaved,
  output logic [LOW_W-1:0]  flagRestored
);

  pcCtl_t            ctl;
  logic [ADDR_W-1:0] popAddr;
  logic [ADDR_W-1:0] pushAddr;

  pc_ctrl uCtrl (
    .irqTake (irqTake),
    .retiEn  (retiEn),
    .retEn   (retEn),
    .callEn  (callEn),
    .jmpEn   (jmpEn),
    .addPclEn(addPclEn),
    .subPclEn(subPclEn),
    .ctl     (ctl)
  );

  pc_datapath #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .VEC(VEC)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .target  (targetAddr),
    .acc     (accIn),
    .popAddr (popAddr),
    .pc      (fetchAddr),
    .pushAddr(pushAddr),
    .gie     (gieOut)
  );

  ret_stack #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .DEPTH(DEPTH)) uStack (
    .clk     (clk),
    .rstN    (rstN),
    .push    (ctl.push),
    .pop     (ctl.pop),
    .pushAddr(pushAddr),
    .topAddr (popAddr),
    .sp      (stackPtr)
  );

  shadow_buf #(.DATA_W(LOW_W)) uShadow (
    .clk         (clk),
    .rstN        (rstN),
    .saveEn      (shadowSave),
    .accIn       (accIn),
    .flagIn      (flagIn),
    .accSaved    (accSaved),
    .flagRestored(flagRestored)
  );

endmodule

// File: rtl/fetch_pc_unit_chk.sv
module fetch_pc_unit_chk #(
  parameter int ADDR_W = 10,
  parameter int LOW_W  = 8,
  parameter int DEPTH  = 4,
  parameter int VEC    = 8,
  localparam int SP_W  = $clog2(DEPTH),
  localparam int HI_W  = ADDR_W - LOW_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              jmpEn,
  input logic              callEn,
  input logic              retEn,
  input logic              retiEn,
  input logic              irqTake,
  input logic              addPclEn,
  input logic              subPclEn,
  input logic [ADDR_W-1:0] targetAddr,
  input logic [LOW_W-1:0]  accIn,
  input logic [LOW_W-1:0]  flagIn,
  input logic              shadowSave,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [SP_W-1:0]   stackPtr,
  input logic              gieOut,
  input logic [LOW_W-1:0]  accSaved,
  input logic [LOW_W-1:0]  flagRestored
);

  logic anyStrobe, onlyAdd, onlySub, onlyRet, onlyCall;
  logic [LOW_W:0]   wideSum;
  logic [HI_W-1:0]  hiPart;

  assign anyStrobe = irqTake | retiEn | retEn | callEn | jmpEn | addPclEn | subPclEn;
  assign onlyCall  = callEn & ~(irqTake | retiEn | retEn);
  assign onlyRet   = retEn & ~(irqTake | retiEn);
  assign onlyAdd   = addPclEn & ~(irqTake | retiEn | retEn | callEn | jmpEn);
  assign onlySub   = subPclEn & ~(irqTake | retiEn | retEn | callEn | jmpEn | addPclEn);
  assign wideSum   = {1'b0, fetchAddr[LOW_W-1:0]} + {1'b0, accIn};
  assign hiPart    = fetchAddr[ADDR_W-1:LOW_W];

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    !anyStrobe |=> fetchAddr == ADDR_W'($past(fetchAddr) + ADDR_W'(1)));

  a_r3_call_push: assert property (@(posedge clk) disable iff (!rstN)
    onlyCall |=> fetchAddr == $past(targetAddr) && stackPtr == SP_W'($past(stackPtr) + SP_W'(1)));

  a_r4_ret_pop: assert property (@(posedge clk) disable iff (!rstN)
    onlyRet |=> stackPtr == SP_W'($past(stackPtr) - SP_W'(1)));

  a_r5_irq_entry: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |=> fetchAddr == ADDR_W'(VEC) && !gieOut
                && stackPtr == SP_W'($past(stackPtr) + SP_W'(1)));

  a_r6_reti_gie: assert property (@(posedge clk) disable iff (!rstN)
    (retiEn && !irqTake) |=> gieOut);

  a_r7_add_low: assert property (@(posedge clk) disable iff (!rstN)
    onlyAdd |=> fetchAddr[LOW_W-1:0] == $past(wideSum[LOW_W-1:0]));

  a_r7_add_carry: assert property (@(posedge clk) disable iff (!rstN)
    onlyAdd |=> fetchAddr[ADDR_W-1:LOW_W] == HI_W'($past(hiPart) + HI_W'($past(wideSum[LOW_W]))));

  a_r8_sub_keep_high: assert property (@(posedge clk) disable iff (!rstN)
    onlySub |=> fetchAddr[ADDR_W-1:LOW_W] == $past(hiPart));

  a_r11_save_acc: assert property (@(posedge clk) disable iff (!rstN)
    shadowSave |=> accSaved == $past(accIn));

  a_r11_hold_acc: assert property (@(posedge clk) disable iff (!rstN)
    !shadowSave |=> $stable(accSaved));

endmodule

bind fetch_pc_unit fetch_pc_unit_chk #(
  .ADDR_W(ADDR_W), .LOW_W(LOW_W), .DEPTH(DEPTH), .VEC(VEC)
) uChk (.*);

// File: tb/fetch_pc_unit_test.sv
`timescale 1ns/1ps
module fetch_pc_unit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       jmpEn = 0, callEn = 0, retEn = 0, retiEn = 0, irqTake = 0;
  logic       addPclEn = 0, subPclEn = 0, shadowSave = 0;
  logic [9:0] targetAddr = '0;
  logic [7:0] accIn = '0, flagIn = '0;
  logic [9:0] fetchAddr;
  logic [1:0] stackPtr;
  logic       gieOut;
  logic [7:0] accSaved, flagRestored;

  int total = 0, bad = 0;
  bit done = 0;

  int mPc = 0, mSp = 0, mGie = 0, mAcc = 0, mFlag = 0;
  int mStk [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  fetch_pc_unit uut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "fetchAddr", int'(fetchAddr), mPc);
    chk(tag, "stackPtr", int'(stackPtr), mSp);
    chk(tag, "gie", int'(gieOut), mGie);
    chk(tag, "accSaved", int'(accSaved), mAcc);
    chk(tag, "flagRestored", int'(flagRestored), (int'(flagIn) & 'hC0) | mFlag);
  endtask

  task automatic mPush(input int v);
    mStk[mSp] = v;
    mSp = (mSp + 1) % 4;
  endtask

  function automatic int mPop();
    mSp = (mSp + 3) % 4;
    return mStk[mSp];
  endfunction

  task automatic cyc(input string tag);
    int s;
    @(posedge clk);
    if (irqTake) begin
      mPush(mPc); mPc = 8; mGie = 0;
    end else if (retiEn) begin
      mPc = mPop(); mGie = 1;
    end else if (retEn) begin
      mPc = mPop();
    end else if (callEn) begin
      mPush((mPc + 1) % 1024); mPc = int'(targetAddr);
    end else if (jmpEn) begin
      mPc = int'(targetAddr);
    end else if (addPclEn) begin
      s = (mPc % 256) + int'(accIn);
      mPc = ((((mPc / 256) + s / 256) % 4) * 256) + (s % 256);
    end else if (subPclEn) begin
      mPc = (mPc / 256) * 256 + (((mPc % 256) - int'(accIn) + 256) % 256);
    end else begin
      mPc = (mPc + 1) % 1024;
    end
    if (shadowSave) begin
      mAcc = int'(accIn);
      mFlag = int'(flagIn) & 'h3F;
    end
    @(negedge clk);
    compareAll(tag);
    {jmpEn, callEn, retEn, retiEn, irqTake, addPclEn, subPclEn, shadowSave} = '0;
  endtask

  task automatic doJmp(input int a, input string tag);
    jmpEn = 1; targetAddr = 10'(a); cyc(tag);
  endtask
  task automatic doCall(input int a, input string tag);
    callEn = 1; targetAddr = 10'(a); cyc(tag);
  endtask
  task automatic doAdd(input int a, input string tag);
    addPclEn = 1; accIn = 8'(a); cyc(tag);
  endtask
  task automatic doSub(input int a, input string tag);
    subPclEn = 1; accIn = 8'(a); cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    mPc = 1;
    compareAll("R1 after reset");

    // R2: plain increment and wrap at top of space
    repeat (3) cyc("R2 increment");
    doJmp('h3FE, "R3 jump");
    cyc("R2 before wrap");
    cyc("R2 wrap to zero");
    cyc("R2 after wrap");

    // R3/R4: nested calls then returns
    doCall('h100, "R3 call one");
    doCall('h2A0, "R3 call two");
    cyc("R2 inside call");
    retEn = 1; cyc("R4 return two");
    retEn = 1; cyc("R4 return one");

    // R7: computed add with and without carry
    doJmp('h0F0, "R3 jump");
    doAdd('h05, "R7 add no carry");
    doAdd('h20, "R7 add carry");
    doJmp('h3F0, "R3 jump");
    doAdd('h30, "R7 add carry high wraps");
    doAdd('h00, "R7 add zero");

    // R8: computed subtract, borrow leaves high part
    doJmp('h105, "R3 jump");
    doSub('h10, "R8 sub borrow");
    doSub('h05, "R8 sub no borrow");
    doJmp('h300, "R3 jump");
    doSub('h01, "R8 sub borrow at zero");

    // R5/R6: interrupt entry and return from interrupt
    doJmp('h155, "R3 jump");
    irqTake = 1; cyc("R5 irq entry");
    cyc("R2 in handler");
    retiEn = 1; cyc("R6 reti");
    irqTake = 1; cyc("R5 irq clears gie");
    retiEn = 1; cyc("R6 reti again");

    // R9: five pushes overwrite the oldest, pops wrap
    doCall('h010, "R9 push 1");
    doCall('h020, "R9 push 2");
    doCall('h030, "R9 push 3");
    doCall('h040, "R9 push 4");
    doCall('h050, "R9 push 5 overwrite");
    for (int i = 0; i < 5; i++) begin
      retEn = 1; cyc("R9 pop");
    end

    // R10: priority among simultaneous strobes
    doJmp('h200, "R3 jump");
    irqTake = 1; retiEn = 1; callEn = 1; targetAddr = 10'h111; cyc("R10 irq wins");
    retiEn = 1; retEn = 1; callEn = 1; targetAddr = 10'h222; cyc("R10 reti wins");
    retEn = 1; callEn = 1; jmpEn = 1; targetAddr = 10'h333; cyc("R10 ret wins");
    callEn = 1; jmpEn = 1; addPclEn = 1; accIn = 8'h44; targetAddr = 10'h0A0; cyc("R10 call wins");
    jmpEn = 1; addPclEn = 1; subPclEn = 1; accIn = 8'h10; targetAddr = 10'h0C0; cyc("R10 jmp wins");
    addPclEn = 1; subPclEn = 1; accIn = 8'h10; cyc("R10 add wins");
    retEn = 1; cyc("R4 return from call");

    // R11: shadow buffer, cause bits follow the live input
    accIn = 8'h5A; flagIn = 8'hFF; shadowSave = 1; cyc("R11 save");
    flagIn = 8'h00; accIn = 8'h00; cyc("R11 cause bits live low");
    flagIn = 8'h80; cyc("R11 cause bit 7 live");
    accIn = 8'hA5; flagIn = 8'h41; shadowSave = 1; cyc("R11 resave");
    flagIn = 8'hC0; accIn = 8'h33; cyc("R11 hold without save");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule